// File: doc/BRIEF.md
# Processor Write Parity Checker

This block watches processor write transactions on their way to memory and checks the byte parity that travels with the write data. Each data byte has one parity bit under an odd-parity rule. When a write goes to local DRAM and the current configuration allows checking, any byte that is enabled by its lane strobe and carries wrong parity raises an error.

Checking depends on several things. Two enable bits must both be set: one for error reporting and one for write parity checking. The configured memory type and error protocol must form a supported pair. The write must target local memory. Writes to PCI space or to the local ROM space are never checked.

A detected error drives a one-cycle pulse and sets a sticky status bit. The status bit stays set until software clears it with a write-one-to-clear strobe. The write port uses a valid/ready handshake. The checker never applies back-pressure, so ready is held high whenever the block is out of reset. A write is accepted on every clock edge where valid is high, and the upstream source may stream one write per cycle without stalling.

Top module: `proc_wr_parity_chk`

## Requirements
- R1: A byte lane is in error when its 8 data bits and its parity bit together hold an even number of ones (odd parity expected). Data byte i is `wr_data[8i+7:8i]`, and its parity bit is `wr_par[i]`.
- R2: A lane whose strobe bit `wr_strb[i]` is 0 is not checked, so bad parity in that lane raises no error.
- R3: Checking happens only when `en_report` and `en_wpar` are both 1.
- R4: With `cfg_mem_sdram`=1, checking applies for protocol codes 1 (parity) and 3 (ECC). It does not apply for codes 0 (none) or 2 (read-modify-write parity).
- R5: With `cfg_mem_sdram`=0 (FPM/EDO), checking applies only for protocol code 1 (parity).
- R6: Only `wr_space`=0 (local memory) is checked. Codes 1 (PCI), 2 (ROM) and 3 (reserved) are never checked.
- R7: `err_pulse` is high for exactly the one cycle after a clock edge that accepts (`wr_valid`=1) a checked write with at least one lane in error. A cycle with `wr_valid`=0 never causes a pulse.
- R8: `err_sticky` is set by every error and stays set until a clock edge with `clr_w1c`=1. If an error and a clear fall on the same edge, the bit stays set.
- R9: `wr_ready` is 1 on every cycle when not in reset.
- R10: During and right after reset, `err_pulse` and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (always high out of reset) |
| wr_data | input | 64 | Write data |
| wr_par | input | 8 | Per-byte odd parity bits |
| wr_strb | input | 8 | Byte lane strobes |
| wr_space | input | 2 | Target: 0 local, 1 PCI, 2 ROM, 3 reserved |
| cfg_mem_sdram | input | 1 | 1 SDRAM, 0 FPM/EDO DRAM |
| cfg_protocol | input | 2 | 0 none, 1 parity, 2 RMW parity, 3 ECC |
| en_report | input | 1 | Error reporting enable |
| en_wpar | input | 1 | Write parity check enable |
| clr_w1c | input | 1 | Write-one-to-clear for the status bit |
| err_pulse | output | 1 | One-cycle error pulse |
| err_sticky | output | 1 | Sticky parity error status |

## Verification
The assertions assume that the configuration inputs and the enables are sampled together with the write beat at the same edge. They also assume that `rst_n` is driven synchronously to `clk`, so `$past` values always describe the accepted beat. The bench changes configuration only at the falling edge, together with the beat it applies to, so every pulse can be traced back to one set of sampled inputs. The bench does not rely on `wr_ready` for anything other than its R9 check, because the block never throttles.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    SPACE_LOCAL = 2'd0,
    SPACE_PCI   = 2'd1,
    SPACE_ROM   = 2'd2,
    SPACE_RSVD  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    PROT_NONE   = 2'd0,
    PROT_PARITY = 2'd1,
    PROT_RMW    = 2'd2,
    PROT_ECC    = 2'd3
  } proto_e;

  // Odd parity: a byte plus its parity bit holds an odd number of ones.
  function automatic logic lane_bad(input logic [7:0] b, input logic p);
    return ~(^{b, p});
  endfunction

endpackage

// File: rtl/wpc_gate.sv
module wpc_gate
  import wpc_pkg::*;
(
  input  logic [1:0] space,
  input  logic       mem_sdram,
  input  logic [1:0] protocol,
  input  logic       en_report,
  input  logic       en_wpar,
  output logic       check_en
);
  space_e space_q;
  proto_e proto_q;
  logic   matrix_ok;

  assign space_q = space_e'(space);
  assign proto_q = proto_e'(protocol);

  always_comb begin
    matrix_ok = 1'b0;
    if (mem_sdram) begin
      case (proto_q)
        PROT_PARITY, PROT_ECC: matrix_ok = 1'b1;
        default:               matrix_ok = 1'b0;
      endcase
    end else begin
      matrix_ok = (proto_q == PROT_PARITY);
    end
  end

  assign check_en = en_report && en_wpar && matrix_ok && (space_q == SPACE_LOCAL);
endmodule

// File: rtl/wpc_parity.sv
module wpc_parity
  import wpc_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        par,
  input  logic [LANES-1:0]        strb,
  output logic                    any_bad
);
  logic [LANES-1:0] bad_vec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic odd_ones;
    assign odd_ones   = ^{data[g*LANE_W +: LANE_W], par[g]};
    assign bad_vec[g] = strb[g] && !odd_ones;
  end

  assign any_bad = |bad_vec;
endmodule

// File: rtl/wpc_status.sv
module wpc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic pulse,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
    end else begin
      pulse <= hit;
      if (hit)      sticky <= 1'b1;
      else if (clr) sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/proc_wr_parity_chk.sv
module proc_wr_parity_chk #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W/LANE_W-1:0] wr_par,
  input  logic [DATA_W/LANE_W-1:0] wr_strb,
  input  logic [1:0]        wr_space,
  input  logic              cfg_mem_sdram,
  input  logic [1:0]        cfg_protocol,
  input  logic              en_report,
  input  logic              en_wpar,
  input  logic              clr_w1c,
  output logic              err_pulse,
  output logic              err_sticky
);
  localparam int LANES = DATA_W / LANE_W;

  logic check_en;
  logic any_bad;
  logic accept;
  logic hit;

  assign wr_ready = rst_n;
  assign accept   = wr_valid && wr_ready;

  wpc_gate u_gate (
    .space     (wr_space),
    .mem_sdram (cfg_mem_sdram),
    .protocol  (cfg_protocol),
    .en_report (en_report),
    .en_wpar   (en_wpar),
    .check_en  (check_en)
  );

  wpc_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_par (
    .data    (wr_data),
    .par     (wr_par),
    .strb    (wr_strb),
    .any_bad (any_bad)
  );

  assign hit = accept && check_en && any_bad;

  wpc_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .clr    (clr_w1c),
    .pulse  (err_pulse),
    .sticky (err_sticky)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [1:0] wr_space,
  input logic       cfg_mem_sdram,
  input logic [1:0] cfg_protocol,
  input logic       en_report,
  input logic       en_wpar,
  input logic       clr_w1c,
  input logic       err_pulse,
  input logic       err_sticky
);
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  assert_pulse_needs_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(wr_valid));

  assert_pulse_needs_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(en_report && en_wpar));

  assert_pulse_local_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(wr_space) == 2'd0));

  assert_sdram_matrix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && $past(cfg_mem_sdram)) |-> ($past(cfg_protocol) == 2'd1 || $past(cfg_protocol) == 2'd3));

  assert_dram_matrix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !$past(cfg_mem_sdram)) |-> ($past(cfg_protocol) == 2'd1));

  assert_sticky_follows_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  assert_sticky_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> err_pulse);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr_w1c) |=> err_sticky);
endmodule

bind proc_wr_parity_chk wpc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_space      (wr_space),
  .cfg_mem_sdram (cfg_mem_sdram),
  .cfg_protocol  (cfg_protocol),
  .en_report     (en_report),
  .en_wpar       (en_wpar),
  .clr_w1c       (clr_w1c),
  .err_pulse     (err_pulse),
  .err_sticky    (err_sticky)
);

// File: tb/proc_wr_parity_chk_test.sv
module proc_wr_parity_chk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par = '0;
  logic [7:0]  wr_strb = '0;
  logic [1:0]  wr_space = '0;
  logic        cfg_mem_sdram = 1'b1;
  logic [1:0]  cfg_protocol = 2'd1;
  logic        en_report = 1'b1;
  logic        en_wpar = 1'b1;
  logic        clr_w1c = 1'b0;
  logic        err_pulse;
  logic        err_sticky;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ref_sticky = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  proc_wr_parity_chk uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run hung after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += d[i*8+b];
      p[i] = (ones % 2 == 0);
    end
    return p;
  endfunction

  function automatic bit ref_checked();
    bit ok;
    if (!(en_report && en_wpar)) return 1'b0;
    if (wr_space != 2'd0) return 1'b0;
    if (cfg_mem_sdram) ok = (cfg_protocol == 2'd1) || (cfg_protocol == 2'd3);
    else ok = (cfg_protocol == 2'd1);
    return ok;
  endfunction

  function automatic bit ref_bad();
    for (int i = 0; i < 8; i++) begin
      int ones = wr_par[i];
      for (int b = 0; b < 8; b++) ones += wr_data[i*8+b];
      if (wr_strb[i] && (ones % 2 == 0)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Inputs are already driven (at the falling edge); predict, clock, compare.
  task automatic step(input string tag);
    bit exp_pulse;
    exp_pulse  = wr_valid && ref_checked() && ref_bad();
    ref_sticky = exp_pulse ? 1'b1 : (clr_w1c ? 1'b0 : ref_sticky);
    @(posedge clk);
    #2;
    check({tag, " pulse"}, err_pulse, exp_pulse);
    check({tag, " sticky"}, err_sticky, ref_sticky);
    check("R9 ready", wr_ready, 1'b1);
    @(negedge clk);
    wr_valid = 1'b0;
    clr_w1c  = 1'b0;
  endtask

  task automatic beat(input logic [63:0] d, input int bad_lane, input logic [7:0] s);
    wr_valid = 1'b1;
    wr_data  = d;
    wr_par   = good_par(d);
    if (bad_lane >= 0) wr_par[bad_lane] = ~wr_par[bad_lane];
    wr_strb  = s;
  endtask

  task automatic clear_status();
    clr_w1c = 1'b1;
    step("R8 clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 pulse in reset", err_pulse, 1'b0);
    check("R10 sticky in reset", err_sticky, 1'b0);
    rst_n = 1'b1;
    step("R10 after reset");

    // Main function, several patterns
    beat(64'h0123_4567_89AB_CDEF, -1, 8'hFF); step("R1 good data");
    beat(64'hFFFF_0000_A5A5_5A5A, -1, 8'hFF); step("R1 good data 2");
    beat(64'h0123_4567_89AB_CDEF, 3, 8'hFF);  step("R1 bad lane 3");
    step("R7 pulse one cycle");
    beat(64'h0, 7, 8'hFF);                     step("R1 bad lane 7 zero data");
    clear_status();

    // Back-to-back errors
    beat(64'h1111_2222_3333_4444, 0, 8'hFF); step("R7 back-to-back 1");
    beat(64'h5555_6666_7777_8888, 4, 8'hFF); step("R7 back-to-back 2");
    clear_status();

    // Strobes
    beat(64'hDEAD_BEEF_CAFE_F00D, 5, 8'hDF); step("R2 masked lane");
    beat(64'hDEAD_BEEF_CAFE_F00D, 5, 8'h20); step("R2 only bad lane on");
    clear_status();
    beat(64'hDEAD_BEEF_CAFE_F00D, 2, 8'h00); step("R2 no lanes");

    // Valid low
    beat(64'h0, 1, 8'hFF); wr_valid = 1'b0; step("R7 valid low");

    // Enables
    for (int e = 0; e < 4; e++) begin
      en_report = e[0]; en_wpar = e[1];
      beat(64'h0F0F_0F0F_F0F0_F0F0, 6, 8'hFF); step("R3 enables");
      clear_status();
    end
    en_report = 1'b1; en_wpar = 1'b1;

    // Support matrix
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        cfg_mem_sdram = m[0]; cfg_protocol = p[1:0];
        beat(64'h8000_0000_0000_0001, 0, 8'hFF);
        step(m[0] ? "R4 sdram matrix" : "R5 fpm/edo matrix");
        clear_status();
      end
    end
    cfg_mem_sdram = 1'b1; cfg_protocol = 2'd1;

    // Target space
    for (int s = 0; s < 4; s++) begin
      wr_space = s[1:0];
      beat(64'h7777_7777_7777_7777, 1, 8'hFF); step("R6 target space");
      clear_status();
    end
    wr_space = 2'd0;

    // Clear with no error, then set and clear on same edge
    beat(64'h0, 2, 8'hFF); step("R8 set");
    step("R8 hold");
    beat(64'h0, 3, 8'hFF); clr_w1c = 1'b1; step("R8 set beats clear");
    clear_status();
    step("R8 stays clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule